// File: doc/BRIEF.md
# Transmit Byte Serializer with Switchable Byte Clock

This block takes bytes from a framer and sends them out one bit per transmit clock, most significant bit first. The transmit clock is normally the synthesized bit clock. With loop timing selected, the recovered receive clock takes its place. Either way, one byte period is eight transmit clocks, and a fresh byte is loaded into the shifter at the end of each period.

The byte clock can run in either direction, chosen by `clk_dir_out`. When the input is high, the block makes the byte clock itself by dividing the transmit clock by eight. It drives that clock out with its enable set, and samples `tx_data` on each rising edge. When the input is low, which is the state a pull-down gives an open pin, the framer supplies the byte clock. Bytes are then written on its rising edges into a four-entry dual-clock FIFO with Gray-coded pointers. Because of this FIFO, the framer clock may have any phase relative to the transmit clock and may carry some jitter.

A single controller sets what is loaded at each byte boundary. It has three states:
- `ST_IDLE`: the state after reset. It sends zero bytes until the first byte is ready.
- `ST_RUN`: it streams bytes.
- `ST_RESYNC`: it sends zero bytes after a slip.

Its transitions are:
- IDLE→RUN: taken when the first byte is ready. In output mode that is the first sampled byte. In input mode it is two FIFO entries.
- RUN→RUN: the steady byte load.
- RUN→RESYNC: taken when the FIFO is empty or full at a load. This raises a sticky error.
- RESYNC→RUN: taken once two entries lie ahead again. The read pointer is then re-centred two entries behind the write pointer.

Top module: `txs_serializer`

## Requirements
- R1: With `clk_dir_out` low, `byte_clk_oe` and `byte_clk_o` stay low, and a byte is written from `tx_data` on every rising edge of `byte_clk_i`.
- R2: With `clk_dir_out` high, `byte_clk_oe` is high and `byte_clk_o` has a period of eight transmit clocks, high for the last four of each byte period.
- R3: In output mode, `tx_data` is sampled at the transmit clock edge where `byte_clk_o` rises. That byte starts on `ser_out` four transmit clocks later and fills the next byte period.
- R4: Each byte leaves `ser_out` most significant bit first, one bit per transmit clock.
- R5: `ser_out` is zero until the first byte is ready. In output mode this means the first eight bits after reset are zero.
- R6: In input mode, with a framer clock at the byte rate of any phase and ±2 ns of period jitter, every written byte appears on `ser_out` once, in write order, with no error raised.
- R7: In input mode, reading starts only once two entries have been written. A single written byte is never sent on its own.
- R8: On underflow (an empty FIFO at a load), `slip_err` is set and zero bytes are sent. Streaming resumes in order, with no repeated byte, once two new entries exist.
- R9: On overflow (a full FIFO at a load), `slip_err` is set and reading restarts two entries behind the write pointer. Later bytes keep their order without repeats.
- R10: `slip_err` stays set until reset and is never set in output mode.
- R11: With `loop_time` high, `rec_clk` is the transmit clock, so the `byte_clk_o` period is eight `rec_clk` periods.
- R12: During reset, `ser_out`, `slip_err` and `byte_clk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Synthesized transmit bit clock |
| rec_clk | input | 1 | Recovered receive clock, used for loop timing |
| loop_time | input | 1 | 1 selects `rec_clk` as the transmit clock |
| rst | input | 1 | Asynchronous active-high reset |
| clk_dir_out | input | 1 | 1 = block drives the byte clock, 0 = framer drives it |
| byte_clk_i | input | 1 | Byte clock from the framer (input mode) |
| byte_clk_o | output | 1 | Byte clock driven to the framer (output mode) |
| byte_clk_oe | output | 1 | Output enable for the byte clock pad |
| tx_data | input | 8 | Parallel transmit byte |
| ser_out | output | 1 | Serial transmit data |
| slip_err | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
The bench has four targets. First, it holds back the second framer write for a long time. A design that started reading after only one entry would send that byte early. Second, it stops the framer clock to cause an underflow and then restarts it. A design that moved the read pointer back on underflow would resend stale entries, and a design that lost track would drop bytes. Third, it runs the framer clock too fast to cause an overflow. A design that did not re-centre would send bytes out of order. Fourth, it compares byte-clock periods under both timing sources. This exposes a divider of the wrong ratio, or a source selection that ignores `loop_time`.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RESYNC = 2'd2
    } ser_state_e;
endpackage

// File: rtl/txs_clk_sel.sv
module txs_clk_sel (
    input  logic clk_syn,
    input  logic clk_rec,
    input  logic use_rec,
    output logic clk_o
);
    // Static selection between synthesized and recovered timing; changed under reset.
    assign clk_o = use_rec ? clk_rec : clk_syn;
endmodule

// File: rtl/txs_byte_fifo.sv
module txs_byte_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic                       wr_clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_clk,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]     wptr_sync
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wbin, wbin_nx, wgray;
    logic [PW-1:0]    gsync1, gsync2;

    assign wbin_nx = wbin + 1'b1;

    // Write side, framer clock domain
    always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= (wbin_nx >> 1) ^ wbin_nx;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    // Two-stage synchronizer of the Gray write pointer into the transmit domain
    always_ff @(posedge rd_clk or posedge rst) begin
        if (rst) begin
            gsync1 <= '0;
            gsync2 <= '0;
        end else begin
            gsync1 <= wgray;
            gsync2 <= gsync1;
        end
    end

    assign wptr_sync = gray_to_bin(gsync2);
    assign rd_data   = mem[rd_addr];
endmodule

// File: rtl/txs_ser_ctrl.sv
module txs_ser_ctrl
    import txs_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LAG   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      out_mode,
    input  logic [WIDTH-1:0]          tx_data,
    input  logic [$clog2(DEPTH):0]    fifo_wptr,
    input  logic [WIDTH-1:0]          fifo_data,
    output logic [$clog2(DEPTH)-1:0]  fifo_raddr,
    output logic                      ser_out,
    output logic                      byte_clk_o,
    output logic                      slip_err,
    output ser_state_e                state_o
);
    localparam int unsigned AW      = $clog2(DEPTH);
    localparam int unsigned PW      = AW + 1;
    localparam int unsigned CW      = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST  = CW'(WIDTH - 1);
    localparam logic [CW-1:0] CAPT  = CW'(WIDTH / 2 - 1);
    localparam logic [PW-1:0] LAG_P = PW'(LAG);
    localparam logic [PW-1:0] DEP_P = PW'(DEPTH);

    ser_state_e       state, state_nx;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] shreg, hold, load_val;
    logic             hvalid, load, slip;
    logic [PW-1:0]    rptr, rptr_nx, fill, back;

    assign load       = (cnt == LAST);
    assign fill       = fifo_wptr - rptr;
    assign back       = fifo_wptr - LAG_P;
    assign fifo_raddr = (state == ST_RUN) ? rptr[AW-1:0] : back[AW-1:0];

    // Decision at each byte boundary: next state, byte to load, read pointer
    always_comb begin
        state_nx = state;
        load_val = '0;
        rptr_nx  = rptr;
        slip     = 1'b0;
        if (load) begin
            unique case (state)
                ST_IDLE, ST_RESYNC: begin
                    if (out_mode) begin
                        if (hvalid) begin
                            load_val = hold;
                            state_nx = ST_RUN;
                        end
                    end else if (fill >= LAG_P) begin
                        load_val = fifo_data;
                        rptr_nx  = back + 1'b1;
                        state_nx = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (out_mode) begin
                        load_val = hold;
                    end else if (fill == '0 || fill >= DEP_P) begin
                        slip     = 1'b1;
                        state_nx = ST_RESYNC;
                    end else begin
                        load_val = fifo_data;
                        rptr_nx  = rptr + 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Output registers: divider, capture, shifter, read pointer, error flag
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt      <= '0;
            shreg    <= '0;
            hold     <= '0;
            hvalid   <= 1'b0;
            rptr     <= '0;
            slip_err <= 1'b0;
        end else begin
            cnt   <= load ? '0 : cnt + 1'b1;
            shreg <= load ? load_val : {shreg[WIDTH-2:0], 1'b0};
            rptr  <= rptr_nx;
            if (slip) slip_err <= 1'b1;
            if (out_mode && cnt == CAPT) begin
                hold   <= tx_data;
                hvalid <= 1'b1;
            end
        end
    end

    assign ser_out    = shreg[WIDTH-1];
    assign byte_clk_o = out_mode & (cnt > CAPT);
    assign state_o    = state;
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer
    import txs_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned START_LAG  = 2
) (
    input  logic              bit_clk,
    input  logic              rec_clk,
    input  logic              loop_time,
    input  logic              rst,
    input  logic              clk_dir_out,
    input  logic              byte_clk_i,
    output logic              byte_clk_o,
    output logic              byte_clk_oe,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              ser_out,
    output logic              slip_err
);
    localparam int unsigned AW = $clog2(FIFO_DEPTH);

    logic              tx_clk;
    logic [AW:0]       wptr_s;
    logic [AW-1:0]     raddr;
    logic [BYTE_W-1:0] rdata;
    ser_state_e        ctl_state;

    txs_clk_sel u_clk (
        .clk_syn (bit_clk),
        .clk_rec (rec_clk),
        .use_rec (loop_time),
        .clk_o   (tx_clk)
    );

    txs_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .wr_clk    (byte_clk_i),
        .rst       (rst),
        .wr_en     (~clk_dir_out),
        .wr_data   (tx_data),
        .rd_clk    (tx_clk),
        .rd_addr   (raddr),
        .rd_data   (rdata),
        .wptr_sync (wptr_s)
    );

    txs_ser_ctrl #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH), .LAG(START_LAG)) u_ctrl (
        .clk        (tx_clk),
        .rst        (rst),
        .out_mode   (clk_dir_out),
        .tx_data    (tx_data),
        .fifo_wptr  (wptr_s),
        .fifo_data  (rdata),
        .fifo_raddr (raddr),
        .ser_out    (ser_out),
        .byte_clk_o (byte_clk_o),
        .slip_err   (slip_err),
        .state_o    (ctl_state)
    );

    assign byte_clk_oe = clk_dir_out;
endmodule

// File: rtl/txs_serializer_chk.sv
module txs_serializer_chk
    import txs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_dir_out,
    input logic       byte_clk_o,
    input logic       byte_clk_oe,
    input logic       ser_out,
    input logic       slip_err,
    input ser_state_e state
);
    logic        prev_bco, seen_rise, bco_rise;
    int unsigned since_rise;

    assign bco_rise = byte_clk_o && !prev_bco;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            prev_bco   <= 1'b0;
            seen_rise  <= 1'b0;
            since_rise <= 0;
        end else begin
            prev_bco <= byte_clk_o;
            if (bco_rise) begin
                seen_rise  <= 1'b1;
                since_rise <= 0;
            end else begin
                since_rise <= since_rise + 1;
            end
        end
    end

    // R2: byte clock rises once per BYTE_W transmit clocks
    p_byte_clk_period_r2: assert property (@(posedge clk) disable iff (rst)
        (bco_rise && seen_rise) |-> (since_rise == BYTE_W - 1));

    // R1: pad neither enabled nor toggled when the framer drives the clock
    p_input_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !clk_dir_out |-> (!byte_clk_o && !byte_clk_oe));

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        slip_err |=> slip_err);

    // R10: no slip in output mode
    p_no_err_out_r10: assert property (@(posedge clk) disable iff (rst)
        clk_dir_out |-> !slip_err);

    // R5 / R8: zero bits whenever not streaming
    p_zero_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> !ser_out);
endmodule

bind txs_serializer txs_serializer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (tx_clk),
    .rst         (rst),
    .clk_dir_out (clk_dir_out),
    .byte_clk_o  (byte_clk_o),
    .byte_clk_oe (byte_clk_oe),
    .ser_out     (ser_out),
    .slip_err    (slip_err),
    .state       (ctl_state)
);

// File: tb/txs_serializer_test.sv
`timescale 1ns/1ps
module txs_serializer_test;
    logic       bit_clk = 1'b0;
    logic       rec_clk = 1'b0;
    logic       loop_time = 1'b0;
    logic       rst = 1'b0;
    logic       clk_dir_out = 1'b1;
    logic       byte_clk_i = 1'b0;
    logic [7:0] tx_data = 8'h80;
    logic       byte_clk_o, byte_clk_oe, ser_out, slip_err;
    logic       mon_clk;

    int checks = 0;
    int fails  = 0;
    int mon_mode = 0;   // 0 off, 1 exact order, 2 ordered no gaps, 3 ordered may skip
    int n = 0, nb = 0, nxt = 0, last_idx = -1, wk = 0;
    logic [7:0] acc = 8'h00;

    always #4 bit_clk = ~bit_clk;   // 125 MHz
    always #5 rec_clk = ~rec_clk;
    assign mon_clk = loop_time ? rec_clk : bit_clk;

    txs_serializer uut (
        .bit_clk(bit_clk), .rec_clk(rec_clk), .loop_time(loop_time), .rst(rst),
        .clk_dir_out(clk_dir_out), .byte_clk_i(byte_clk_i), .byte_clk_o(byte_clk_o),
        .byte_clk_oe(byte_clk_oe), .tx_data(tx_data), .ser_out(ser_out), .slip_err(slip_err)
    );

    function automatic logic [7:0] seq(int k);
        return {1'b1, 7'(k)};
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: serial bit stream reassembled into byte periods
    always @(negedge mon_clk) begin
        if (rst) begin
            n = 0; nb = 0; nxt = 0; last_idx = -1; acc = 8'h00;
        end else begin
            n++;
            acc = {acc[6:0], ser_out};
            if (mon_mode == 1 && n < 8) chk(ser_out == 1'b0, "R5", ser_out, 0);
            if (n >= 8 && ((n - 8) % 8) == 7) begin
                if (mon_mode == 1) begin
                    chk(acc == seq(nb), "R4", acc, seq(nb));   // R3 timing, R4 bit order
                end else if (mon_mode == 2 && acc != 8'h00) begin
                    chk(acc == seq(nxt), "R6", acc, seq(nxt));
                    nxt++;
                end else if (mon_mode == 3 && acc != 8'h00) begin
                    chk(int'(acc[6:0]) > last_idx, "R9", acc[6:0], last_idx + 1);
                    last_idx = int'(acc[6:0]);
                end
                nb++;
            end
        end
    end

    task automatic do_reset(bit om, bit lt);
        mon_mode = 0;
        rst = 1'b1;
        clk_dir_out = om;
        loop_time = lt;
        byte_clk_i = 1'b0;
        tx_data = seq(0);
        wk = 0;
        repeat (4) @(negedge mon_clk);
        #1 rst = 1'b0;
    endtask

    task automatic run_out(int count, real per);
        realtime t_prev = 0.0;
        for (int k = 0; k < count; k++) begin
            @(posedge byte_clk_o);
            if (k == 3) chk(($realtime - t_prev) > per - 0.01 && ($realtime - t_prev) < per + 0.01,
                            loop_time ? "R11" : "R2", longint'($realtime - t_prev), longint'(per));
            t_prev = $realtime;
            @(negedge mon_clk);
            tx_data = seq(k + 1);
        end
    endtask

    task automatic write_bytes(int count, int lo_a, int lo_b, int hi);
        for (int k = 0; k < count; k++) begin
            tx_data = seq(wk);
            #((k % 2) ? lo_b : lo_a);
            byte_clk_i = 1'b1;
            #(hi);
            byte_clk_i = 1'b0;
            wk++;
        end
    endtask

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R12: reset state
        #1 rst = 1'b1;
        repeat (3) @(negedge bit_clk);
        chk(ser_out == 1'b0, "R12", ser_out, 0);
        chk(slip_err == 1'b0, "R12", slip_err, 0);
        chk(byte_clk_o == 1'b0, "R12", byte_clk_o, 0);

        // Output mode, synthesized clock: R2 R3 R4 R5
        do_reset(1'b1, 1'b0);
        mon_mode = 1;
        chk(byte_clk_oe == 1'b1, "R2", byte_clk_oe, 1);
        run_out(20, 64.0);
        mon_mode = 0;
        chk(slip_err == 1'b0, "R10", slip_err, 0);

        // Output mode, loop timing: R11
        do_reset(1'b1, 1'b1);
        mon_mode = 1;
        run_out(12, 80.0);
        mon_mode = 0;

        // Input mode: R1 R7 R6 R8
        do_reset(1'b0, 1'b0);
        mon_mode = 2;
        #3;
        chk(byte_clk_oe == 1'b0 && byte_clk_o == 1'b0, "R1", {byte_clk_oe, byte_clk_o}, 0);
        write_bytes(1, 30, 30, 34);
        #640;
        chk(nxt == 0, "R7", nxt, 0);
        write_bytes(29, 28, 32, 34);
        chk(slip_err == 1'b0, "R6", slip_err, 0);
        #512;
        chk(nxt == 30, "R6", nxt, 30);
        chk(slip_err == 1'b1, "R8", slip_err, 1);
        write_bytes(15, 30, 30, 34);
        #512;
        chk(nxt == 45, "R8", nxt, 45);

        // Overflow: R9 R10
        do_reset(1'b0, 1'b0);
        mon_mode = 3;
        #5;
        write_bytes(24, 20, 20, 28);
        chk(slip_err == 1'b1, "R9", slip_err, 1);
        write_bytes(10, 30, 30, 34);
        #512;
        chk(last_idx == 33, "R9", last_idx, 33);
        chk(slip_err == 1'b1, "R10", slip_err, 1);
        mon_mode = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule